// File: doc/BRIEF.md
# Divided-Clock Phase Calibration Sequencer

This block tunes, lane by lane, the timing margin of the transfer from a fast capture clock into a slower divided clock inside a read-data deserializer. It starts once the earlier calibration step reports completion and a start request arrives. For each byte lane it steps the shared divided-clock phase forward one tap at a time. After every step it waits a fixed settle time, then samples an external pass/fail checker. The sweep stops at the first failure or when the tap counter saturates.

The phase is then brought back to its start point with matching decrement strobes. The lane's divided-clock inversion select is driven to 1 and the sweep is repeated. The polarity that gave more passing steps is kept for that lane. When every lane is settled the block raises its done flag, which releases the next calibration step. The inversion selects stay frozen from then on.

Top module: `divclk_phase_cal`

## Requirements
- R1: After synchronous reset `cal_done`, `step_up`, `step_down` and every bit of `inv_sel` are 0, and `lane_idx` is 0.
- R2: Calibration begins only on a clock edge where `start` and `stage_prev_done` are both 1. A `start` while `stage_prev_done` is 0 produces no strobe and no done.
- R3: Every sweep begins with SETTLE cycles without strobes. The same gap follows each `step_up`, and `handoff_ok` is sampled in the last cycle of that gap.
- R4: A sweep issues one single-cycle `step_up` per passing sample and stops at the first sample where `handoff_ok` is 0. The margin is the number of `step_up` strobes issued.
- R5: If the tap count reaches 2^TAP_W-1 while still passing, the sweep stops there and the margin is 2^TAP_W-1.
- R6: For each lane, the first sweep runs with `inv_sel[lane]` at 0 and the second sweep runs with it at 1.
- R7: After the second sweep `inv_sel[lane]` becomes 1 only if its margin is strictly larger than the first sweep's margin. On a tie it becomes 0.
- R8: After the failing or saturating sample, the block issues exactly as many back-to-back single-cycle `step_down` strobes as `step_up` strobes in that sweep. It never asserts both strobes in one cycle, and the net phase offset is zero before the next sweep.
- R9: Lanes are processed in ascending order from 0 to LANES-1, and `lane_idx` shows the lane under calibration.
- R10: `cal_done` rises one cycle after the last lane's decision and then holds `inv_sel` stable. A `start` while calibration runs is ignored. A qualified `start` while done clears `cal_done` and `inv_sel` and runs calibration again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_prev_done | input | 1 | Earlier calibration step has completed |
| start | input | 1 | Calibration request |
| handoff_ok | input | 1 | Pass/fail result of the fast-to-divided transfer, 1 = pass |
| step_up | output | 1 | One-cycle phase increment strobe |
| step_down | output | 1 | One-cycle phase decrement strobe |
| lane_idx | output | clog2(LANES) | Lane currently being calibrated |
| inv_sel | output | LANES | Per-lane divided-clock inversion select |
| cal_done | output | 1 | Calibration finished |

## Verification
The bench models the transfer checker as a pass window: each lane and polarity gets its own failure threshold, applied to a phase offset that the bench rebuilds from the strobes. The thresholds cover several cases. Zero margin tests a sweep with no steps. Thresholds of exactly and beyond the tap maximum test saturation. Equal margins test the tie rule, and either polarity winning tests both outcomes. A second run with new thresholds starts from the done state and shows that stale selects are cleared. A start without the prior-stage flag, and a start pulsed in the middle of a run, show the two ways a request must be ignored.

// File: rtl/divclk_phase_cal.sv
module divclk_phase_cal #(
  parameter int LANES  = 8,
  parameter int TAP_W  = 6,
  parameter int SETTLE = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  stage_prev_done,
  input  logic                                  start,
  input  logic                                  handoff_ok,
  output logic                                  step_up,
  output logic                                  step_down,
  output logic [(LANES>1?$clog2(LANES):1)-1:0]  lane_idx,
  output logic [LANES-1:0]                      inv_sel,
  output logic                                  cal_done
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int TW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_INC, ST_DEC, ST_NEXT, ST_DONE} st_t;
  st_t st;

  logic [TW-1:0]    tmr;
  logic [TAP_W-1:0] taps, marg, marg0;
  logic [LW-1:0]    lane;
  logic             pol;

  wire go        = start && stage_prev_done && (st == ST_IDLE || st == ST_DONE);
  wire settled   = (tmr == TW'(SETTLE - 1));
  wire last_lane = (lane == LW'(LANES - 1));

  assign step_up   = (st == ST_INC);
  assign step_down = (st == ST_DEC);
  assign lane_idx  = lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      taps     <= '0;
      marg     <= '0;
      marg0    <= '0;
      lane     <= '0;
      pol      <= 1'b0;
      inv_sel  <= '0;
      cal_done <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (go) begin
            st       <= ST_SETTLE;
            tmr      <= '0;
            taps     <= '0;
            lane     <= '0;
            pol      <= 1'b0;
            inv_sel  <= '0;
            cal_done <= 1'b0;
          end
        end
        ST_SETTLE: begin
          tmr <= tmr + 1'b1;
          if (settled) begin
            tmr <= '0;
            if (!handoff_ok || taps == TAP_MAX) begin
              marg <= taps;
              st   <= (taps == '0) ? ST_NEXT : ST_DEC;
            end else begin
              st <= ST_INC;
            end
          end
        end
        ST_INC: begin
          taps <= taps + 1'b1;
          st   <= ST_SETTLE;
        end
        ST_DEC: begin
          taps <= taps - 1'b1;
          if (taps == TAP_W'(1)) st <= ST_NEXT;
        end
        ST_NEXT: begin
          tmr  <= '0;
          taps <= '0;
          if (!pol) begin
            marg0         <= marg;
            pol           <= 1'b1;
            inv_sel[lane] <= 1'b1;
            st            <= ST_SETTLE;
          end else begin
            inv_sel[lane] <= (marg > marg0);
            pol           <= 1'b0;
            if (last_lane) begin
              st       <= ST_DONE;
              cal_done <= 1'b1;
            end else begin
              lane <= lane + 1'b1;
              st   <= ST_SETTLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [TAP_W:0] net;
  always_ff @(posedge clk) begin
    if (rst) net <= '0;
    else     net <= net + (TAP_W+1)'(step_up) - (TAP_W+1)'(step_down);
  end

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_down));

  p_net_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NEXT) |-> (net == '0));

  p_no_early_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && !settled) |=> !step_up);

  p_tap_cap_r5: assert property (@(posedge clk) disable iff (rst)
    step_up |-> (net < (TAP_W+1)'(TAP_MAX)));

  p_second_pol_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && pol) |-> inv_sel[lane]);

  p_lane_order_r9: assert property (@(posedge clk) disable iff (rst)
    (lane != $past(lane)) |-> (lane == $past(lane) + 1'b1 || lane == '0));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cal_done && $past(cal_done)) |-> $stable(inv_sel));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && start) |=> (st != ST_IDLE && st != ST_DONE) || cal_done);
endmodule

// File: tb/divclk_phase_cal_test.sv
module divclk_phase_cal_test;
  localparam int S   = 16;
  localparam int MAX = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prev = 1'b0;
  logic start = 1'b0;
  logic ok;
  logic up, dn, done;
  logic [2:0] lane_idx;
  logic [7:0] inv_sel;

  divclk_phase_cal uut (
    .clk(clk), .rst(rst), .stage_prev_done(prev), .start(start), .handoff_ok(ok),
    .step_up(up), .step_down(dn), .lane_idx(lane_idx), .inv_sel(inv_sel), .cal_done(done)
  );

  always #2 clk = ~clk;

  int thr0[8];
  int thr1[8];
  int offset;
  int thr_now;
  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int glitch_at = -1;
  logic [7:0] exp_inv;
  bit finished = 0;

  always @(posedge clk) begin
    if (rst) offset <= 0;
    else     offset <= offset + int'(up) - int'(dn);
  end

  always_comb thr_now = inv_sel[lane_idx] ? thr1[lane_idx] : thr0[lane_idx];
  assign ok = (offset < thr_now);

  task automatic expect_cyc(input logic ei, input logic ed, input logic edn,
                            input int el, input logic [7:0] einv, input string tag);
    nchk++;
    if (up !== ei || dn !== ed || done !== edn || int'(lane_idx) != el || inv_sel !== einv) begin
      nfail++;
      $display("FAIL %s cyc %0d: up/dn/done/lane/inv = %b%b%b/%0d/%h expected %b%b%b/%0d/%h",
               tag, cyc, up, dn, done, lane_idx, inv_sel, ei, ed, edn, el, einv);
    end
    start = (cyc == glitch_at);
    cyc++;
    @(negedge clk);
  endtask

  task automatic sweep(input int ln, input int m, input string tag_hold);
    string t;
    t = (m == MAX) ? "R5" : "R4";
    for (int i = 0; i < m; i++) begin
      repeat (S) expect_cyc(0, 0, 0, ln, exp_inv, "R3");
      expect_cyc(1, 0, 0, ln, exp_inv, t);
    end
    repeat (S) expect_cyc(0, 0, 0, ln, exp_inv, "R3");
    repeat (m) expect_cyc(0, 1, 0, ln, exp_inv, "R8");
    expect_cyc(0, 0, 0, ln, exp_inv, tag_hold);
  endtask

  task automatic run_cal();
    int m0, m1;
    prev  = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    exp_inv = '0;
    for (int ln = 0; ln < 8; ln++) begin
      m0 = (thr0[ln] > MAX) ? MAX : thr0[ln];
      m1 = (thr1[ln] > MAX) ? MAX : thr1[ln];
      sweep(ln, m0, "R9");
      exp_inv[ln] = 1'b1;
      sweep(ln, m1, "R6");
      exp_inv[ln] = (m1 > m0);
    end
    repeat (12) expect_cyc(0, 0, 1, 7, exp_inv, "R7");
    glitch_at = -1;
    start = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin thr0[i] = 100; thr1[i] = 100; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    repeat (3) expect_cyc(0, 0, 0, 0, 8'h00, "R1");

    prev  = 1'b0;
    start = 1'b1;
    @(negedge clk);
    for (int i = 0; i < S + 8; i++) begin
      nchk++;
      if (up !== 1'b0 || done !== 1'b0) begin
        nfail++;
        $display("FAIL R2: up=%b done=%b expected 0/0 without prior-stage done", up, done);
      end
      @(negedge clk);
    end
    start = 1'b0;

    thr0 = '{5, 0, 12, 63, 3, 7, 20, 2};
    thr1 = '{3, 4, 12, 40, 9, 7, 80, 0};
    glitch_at = 100;
    run_cal();
    nchk++;
    if (inv_sel !== 8'b0101_0010) begin
      nfail++;
      $display("FAIL R7: inv_sel=%b expected %b", inv_sel, 8'b0101_0010);
    end

    thr0 = '{2, 6, 0, 1, 9, 4, 3, 11};
    thr1 = '{2, 1, 1, 0, 10, 4, 70, 5};
    glitch_at = 3000;
    run_cal();
    nchk++;
    if (inv_sel !== 8'b0101_0100) begin
      nfail++;
      $display("FAIL R10: inv_sel=%b expected %b after rerun", inv_sel, 8'b0101_0100);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule